// File: doc/BRIEF.md
# Register Write-Lock Guard

This block sits between a simple bus slave port and a bank of byte-wide functional registers, and it decides whether each write reaches them. Its address space has three windows. The direct window reads and writes the registers. The alias window reads and writes the same registers, and a write through it also locks the register it hits. The lock window holds one lock byte for each group of four registers; it reports and changes their lock flags. Once a register is locked, writes to it are refused and the bus sees an error response. Reads are never refused.

A request is presented for one cycle with `busValid`. The response (`rspValid`, `rspData`, `rspErr`) appears in the following cycle. Any write takes effect at the same clock edge that captures the response. The register contents are also driven out in parallel on `regBank`, so the logic they control can use them. The register count and the base of each window are parameters. Every register can be locked.

Top module: `softlock_guard`

## Requirements
- R1: After reset every register reads 0 and every lock byte reads 0, so no register is locked.
- R2: A write to direct address i (0 ≤ i < NUM_REGS) of an unlocked register stores the data byte in register i and gives an error-free response. A direct read returns register i.
- R3: Address MIRROR_BASE+i reads register i. A write there to an unlocked register stores the data and sets the lock flag of register i, with no error.
- R4: A direct write to a locked register leaves it unchanged and gives `rspErr`=1 for that response.
- R5: An alias write to a locked register leaves it unchanged, keeps it locked and gives `rspErr`=1.
- R6: A supervisor write (`busSuper`=1) to lock byte n changes the lock flag in bit 4+m only when bit m of the same data byte is 1; the flag then takes the value of bit 4+m. Bits 0–3 of the lock byte always read as 0.
- R7: A write to a lock byte with `busSuper`=0 changes no lock flag and gives `rspErr`=1. Lock bytes can be read in either mode.
- R8: Lock byte n sits at LOCK_BASE+n, and its bit 4+m holds the lock flag of register 4n+m.
- R9: An address outside the three windows reads as 0, changes no state and gives `rspErr`=1 for both reads and writes.
- R10: `rspValid` is 1 exactly in the cycle after a cycle with `busValid`=1. Reads inside any window give `rspErr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Request present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSuper | input | 1 | Request is made in supervisor mode |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 8 | Write data |
| rspValid | output | 1 | Response present (one cycle after request) |
| rspData | output | 8 | Read data, 0 for writes and errors |
| rspErr | output | 1 | Request refused or unmapped |
| regBank | output | 8*NUM_REGS | All register bytes, register i at bits 8i+7:8i |

## Verification
The bench tries every one of the 256 data bytes on every lock byte. This catches a design that updates a lock flag without its enable bit, updates the wrong flag, or stores the enable bits so that they read back as non-zero. After each lock write it probes one register of the group with a direct write, so a lock byte wired to the wrong group shows up as an error response on an unlocked register, or as missing protection on a locked one. Alias writes to locked registers check that an alias write is not treated as a privileged override. A sweep of every unmapped address checks that a loose decode cannot leak reads or writes into a window.

// File: rtl/softlock_pkg.sv
package softlock_pkg;
  localparam int IDX_W_MAX = 16;

  typedef struct packed {
    logic                 regWr;
    logic                 lockSet;
    logic                 lockWr;
    logic                 rdReg;
    logic                 rdLock;
    logic                 err;
    logic [IDX_W_MAX-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/softlock_ctrl.sv
module softlock_ctrl
  import softlock_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int ADDR_W      = 8,
  parameter int MIRROR_BASE = 64,
  parameter int LOCK_BASE   = 128
) (
  input  logic                busValid,
  input  logic                busWrite,
  input  logic                busSuper,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_REGS-1:0] lockBits,
  output strobe_t             stb
);
  localparam int IW        = $clog2(NUM_REGS);
  localparam int LOCK_REGS = NUM_REGS / 4;
  localparam logic [ADDR_W:0] DIR_END = (ADDR_W+1)'(NUM_REGS);
  localparam logic [ADDR_W:0] MIR_LO  = (ADDR_W+1)'(MIRROR_BASE);
  localparam logic [ADDR_W:0] MIR_END = (ADDR_W+1)'(MIRROR_BASE + NUM_REGS);
  localparam logic [ADDR_W:0] LCK_LO  = (ADDR_W+1)'(LOCK_BASE);
  localparam logic [ADDR_W:0] LCK_END = (ADDR_W+1)'(LOCK_BASE + LOCK_REGS);

  logic [ADDR_W:0] addrExt;
  logic            inDirect, inMirror, inLock;
  logic [IW-1:0]   regIdx, lockIdx;
  logic            isLocked;

  assign addrExt  = {1'b0, busAddr};
  assign inDirect = addrExt < DIR_END;
  assign inMirror = (addrExt >= MIR_LO) && (addrExt < MIR_END);
  assign inLock   = (addrExt >= LCK_LO) && (addrExt < LCK_END);

  always_comb begin
    regIdx  = '0;
    lockIdx = '0;
    if (inMirror)      regIdx = IW'(addrExt - MIR_LO);
    else if (inDirect) regIdx = IW'(addrExt);
    if (inLock)        lockIdx = IW'(addrExt - LCK_LO);
  end

  assign isLocked = lockBits[regIdx];

  always_comb begin
    stb = '0;
    if (busValid) begin
      if (inDirect || inMirror) begin
        stb.idx = IDX_W_MAX'(regIdx);
        if (busWrite) begin
          if (isLocked) begin
            stb.err = 1'b1;
          end else begin
            stb.regWr   = 1'b1;
            stb.lockSet = inMirror;
          end
        end else begin
          stb.rdReg = 1'b1;
        end
      end else if (inLock) begin
        stb.idx = IDX_W_MAX'(lockIdx);
        if (busWrite) begin
          if (busSuper) stb.lockWr = 1'b1;
          else          stb.err    = 1'b1;
        end else begin
          stb.rdLock = 1'b1;
        end
      end else begin
        stb.err = 1'b1;
      end
    end
  end
endmodule

// File: rtl/softlock_datapath.sv
module softlock_datapath
  import softlock_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  busValid,
  input  logic [7:0]            busWdata,
  input  strobe_t               stb,
  output logic [NUM_REGS-1:0]   lockBits,
  output logic                  rspValid,
  output logic [7:0]            rspData,
  output logic                  rspErr,
  output logic [8*NUM_REGS-1:0] regBank
);
  localparam int IW = $clog2(NUM_REGS);

  logic [7:0]          regFile [NUM_REGS];
  logic [NUM_REGS-1:0] lockQ;
  logic [IW-1:0]       regIdx;
  logic [IW-1:0]       lockBase;
  logic [7:0]          rdNext;

  assign regIdx   = stb.idx[IW-1:0];
  assign lockBase = IW'({stb.idx, 2'b00});
  assign lockBits = lockQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
      lockQ <= '0;
    end else begin
      if (stb.regWr) regFile[regIdx] <= busWdata;
      if (stb.lockSet) lockQ[regIdx] <= 1'b1;
      if (stb.lockWr) begin
        for (int m = 0; m < 4; m++) begin
          if (busWdata[m]) lockQ[lockBase + IW'(m)] <= busWdata[4+m];
        end
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (stb.rdReg) begin
      rdNext = regFile[regIdx];
    end else if (stb.rdLock) begin
      for (int m = 0; m < 4; m++) rdNext[4+m] = lockQ[lockBase + IW'(m)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= busValid;
      rspErr   <= stb.err;
      rspData  <= rdNext;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
    assign regBank[8*g +: 8] = regFile[g];
  end
endmodule

// File: rtl/softlock_guard.sv
module softlock_guard
  import softlock_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int ADDR_W      = 8,
  parameter int MIRROR_BASE = 64,
  parameter int LOCK_BASE   = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  busValid,
  input  logic                  busWrite,
  input  logic                  busSuper,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [7:0]            busWdata,
  output logic                  rspValid,
  output logic [7:0]            rspData,
  output logic                  rspErr,
  output logic [8*NUM_REGS-1:0] regBank
);
  strobe_t             stb;
  logic [NUM_REGS-1:0] lockBits;

  softlock_ctrl #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W),
    .MIRROR_BASE(MIRROR_BASE), .LOCK_BASE(LOCK_BASE)
  ) u_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busSuper(busSuper),
    .busAddr(busAddr), .lockBits(lockBits), .stb(stb)
  );

  softlock_datapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rst_n(rst_n), .busValid(busValid), .busWdata(busWdata),
    .stb(stb), .lockBits(lockBits), .rspValid(rspValid),
    .rspData(rspData), .rspErr(rspErr), .regBank(regBank)
  );
endmodule

// File: rtl/softlock_guard_chk.sv
module softlock_guard_chk #(
  parameter int NUM_REGS    = 16,
  parameter int ADDR_W      = 8,
  parameter int MIRROR_BASE = 64,
  parameter int LOCK_BASE   = 128
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busValid,
  input logic                  busWrite,
  input logic                  busSuper,
  input logic [ADDR_W-1:0]     busAddr,
  input logic                  rspValid,
  input logic [7:0]            rspData,
  input logic                  rspErr,
  input logic [8*NUM_REGS-1:0] regBank
);
  localparam int ADDR_SPAN = 1 << ADDR_W;

  int  a;
  logic hitDir, hitMir, hitLck, hitAny;
  assign a      = int'(busAddr);
  assign hitDir = a < NUM_REGS;
  assign hitMir = (a >= MIRROR_BASE) && (a < MIRROR_BASE + NUM_REGS);
  assign hitLck = (a >= LOCK_BASE) && (a < LOCK_BASE + NUM_REGS / 4);
  assign hitAny = hitDir || hitMir || hitLck;

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busValid |=> rspValid);
  // R10
  no_idle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busValid |=> !rspValid);
  // R10
  read_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && !busWrite && hitAny) |=> !rspErr);
  // R9
  unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && !hitAny) |=> (rspErr && rspData == 8'h00));
  // R9
  unmapped_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && busWrite && !hitAny) |=> $stable(regBank));
  // R7
  user_lock_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && busWrite && !busSuper && hitLck) |=> rspErr);
  // R4
  refused_write_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && busWrite && (hitDir || hitMir)) |=> (!rspErr || $stable(regBank)));
endmodule

bind softlock_guard softlock_guard_chk #(
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W),
  .MIRROR_BASE(MIRROR_BASE), .LOCK_BASE(LOCK_BASE)
) u_chk (.*);

// File: tb/tb_softlock_guard.sv
module tb_softlock_guard;
  localparam int CLK_PERIOD  = 10;
  localparam int NUM_REGS    = 16;
  localparam int ADDR_W      = 8;
  localparam int MIRROR_BASE = 64;
  localparam int LOCK_BASE   = 128;
  localparam int LOCK_REGS   = NUM_REGS / 4;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  busValid = 1'b0;
  logic                  busWrite = 1'b0;
  logic                  busSuper = 1'b0;
  logic [ADDR_W-1:0]     busAddr = '0;
  logic [7:0]            busWdata = '0;
  logic                  rspValid;
  logic [7:0]            rspData;
  logic                  rspErr;
  logic [8*NUM_REGS-1:0] regBank;

  int checks = 0;
  int errors = 0;

  logic [7:0] modelReg [NUM_REGS];
  logic       modelLock [NUM_REGS];

  softlock_guard #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W),
    .MIRROR_BASE(MIRROR_BASE), .LOCK_BASE(LOCK_BASE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .busValid(busValid), .busWrite(busWrite),
    .busSuper(busSuper), .busAddr(busAddr), .busWdata(busWdata),
    .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr), .regBank(regBank)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input int a, input logic [7:0] d, input logic s,
                        output logic [7:0] rd, output logic e);
    @(negedge clk);
    busValid = 1'b1; busWrite = w; busAddr = ADDR_W'(a); busWdata = d; busSuper = s;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    rd = rspData; e = rspErr;
    chk("R10 rspValid", 32'(rspValid), 32'd1);
  endtask

  function automatic logic [7:0] lockByte(input int n);
    logic [7:0] b = '0;
    for (int m = 0; m < 4; m++) b[4+m] = modelLock[4*n+m];
    return b;
  endfunction

  function automatic bit unmapped(input int a);
    return !((a < NUM_REGS) || (a >= MIRROR_BASE && a < MIRROR_BASE + NUM_REGS) ||
             (a >= LOCK_BASE && a < LOCK_BASE + LOCK_REGS));
  endfunction

  task automatic checkAll(input string req);
    logic [7:0] rd; logic e;
    for (int i = 0; i < NUM_REGS; i++) begin
      chk(req, 32'(regBank[8*i +: 8]), 32'(modelReg[i]));
    end
    for (int n = 0; n < LOCK_REGS; n++) begin
      access(1'b0, LOCK_BASE + n, 8'h00, 1'b0, rd, e);
      chk(req, 32'(rd), 32'(lockByte(n)));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic       e;
    for (int i = 0; i < NUM_REGS; i++) begin modelReg[i] = '0; modelLock[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R10 idle rspValid", 32'(rspValid), 32'd0);

    // R1: reset state
    for (int i = 0; i < NUM_REGS; i++) begin
      access(1'b0, i, 8'h00, 1'b0, rd, e);
      chk("R1 reg reset", 32'(rd), 32'd0);
    end
    checkAll("R1 lock reset");

    // R2: direct write and read back
    for (int i = 0; i < NUM_REGS; i++) begin
      modelReg[i] = 8'(i * 37 + 5);
      access(1'b1, i, modelReg[i], 1'b0, rd, e);
      chk("R2 write err", 32'(e), 32'd0);
      access(1'b0, i, 8'h00, 1'b0, rd, e);
      chk("R2 readback", 32'(rd), 32'(modelReg[i]));
      chk("R10 read err", 32'(e), 32'd0);
    end

    // R3: alias read, alias write locks even registers
    for (int i = 0; i < NUM_REGS; i++) begin
      access(1'b0, MIRROR_BASE + i, 8'h00, 1'b1, rd, e);
      chk("R3 alias read", 32'(rd), 32'(modelReg[i]));
      if (i % 2 == 0) begin
        modelReg[i] = ~modelReg[i];
        modelLock[i] = 1'b1;
        access(1'b1, MIRROR_BASE + i, modelReg[i], 1'b0, rd, e);
        chk("R3 alias write err", 32'(e), 32'd0);
        access(1'b0, i, 8'h00, 1'b0, rd, e);
        chk("R3 alias write data", 32'(rd), 32'(modelReg[i]));
      end
    end
    checkAll("R8 lock after alias");

    // R4: direct writes against mixed lock state
    for (int i = 0; i < NUM_REGS; i++) begin
      access(1'b1, i, 8'hA5 ^ 8'(i), 1'b1, rd, e);
      chk("R4 err", 32'(e), 32'(modelLock[i]));
      if (!modelLock[i]) modelReg[i] = 8'hA5 ^ 8'(i);
    end
    checkAll("R4 contents");

    // R5: alias writes to locked registers
    for (int i = 0; i < NUM_REGS; i += 2) begin
      access(1'b1, MIRROR_BASE + i, 8'h3C, 1'b1, rd, e);
      chk("R5 err", 32'(e), 32'd1);
    end
    checkAll("R5 contents");

    // R7: user-mode writes to lock bytes
    for (int n = 0; n < LOCK_REGS; n++) begin
      access(1'b1, LOCK_BASE + n, 8'hFF, 1'b0, rd, e);
      chk("R7 err", 32'(e), 32'd1);
      access(1'b0, LOCK_BASE + n, 8'h00, 1'b0, rd, e);
      chk("R7 unchanged", 32'(rd), 32'(lockByte(n)));
      chk("R7 user read err", 32'(e), 32'd0);
    end

    // R6 / R8: every data byte on every lock byte, then probe one register
    for (int n = 0; n < LOCK_REGS; n++) begin
      for (int d = 0; d < 256; d++) begin
        int p;
        for (int m = 0; m < 4; m++) if (d[m]) modelLock[4*n+m] = d[4+m];
        access(1'b1, LOCK_BASE + n, 8'(d), 1'b1, rd, e);
        chk("R6 write err", 32'(e), 32'd0);
        access(1'b0, LOCK_BASE + n, 8'h00, 1'b1, rd, e);
        chk("R6 readback", 32'(rd), 32'(lockByte(n)));
        p = 4*n + (d % 4);
        access(1'b1, p, 8'(d + n), 1'b1, rd, e);
        chk("R8 probe err", 32'(e), 32'(modelLock[p]));
        if (!modelLock[p]) modelReg[p] = 8'(d + n);
      end
    end
    checkAll("R8 final");

    // R9: every unmapped address
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      if (unmapped(a)) begin
        access(1'b0, a, 8'h00, 1'b1, rd, e);
        chk("R9 read data", 32'(rd), 32'd0);
        chk("R9 read err", 32'(e), 32'd1);
        access(1'b1, a, 8'hFF, 1'b1, rd, e);
        chk("R9 write err", 32'(e), 32'd1);
      end
    end
    checkAll("R9 no state change");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule